// File: doc/BRIEF.md
# Shared-Bus Master Transfer Engine

This block is the master side of a simple shared bus that several masters use in turn. It takes one transfer at a time on a valid/ready command port. A command holds an identifier, a 16-bit address, a 2-bit direction, 8 bits of write data, a size code and an idle-delay count. After the engine accepts a command it waits out the delay. It then raises its request line to an external arbiter and waits for the grant. When the grant arrives it runs a one-cycle address phase, followed by a data phase that honours slave wait states. At the end it returns a one-cycle response. The response carries the identifier, the engine's master index, any read data and an error flag.

A single command register is the only buffering. The engine takes no new command until it is back in its idle state. A slave that holds the bus in wait states for too long is cut off by a timeout. The engine then abandons the transfer and reports an error.

Top module: `busm_xfer_engine`

## Requirements
- R1: After reset the engine is idle: `cmd_ready` is 1 and `bus_req`, `bus_addr_phase`, `bus_data_phase` and `rsp_valid` are all 0.
- R2: `cmd_ready` is high only in the idle state. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` stays low until the response has been given.
- R3: The direction code is 0 = no operation, 1 = read, 2 = write, and 3 is treated as no operation. A no-operation command produces `rsp_valid` in the cycle right after acceptance, with error 0 and read data 0, and it never raises `bus_req`.
- R4: For a read or write with delay field d, `bus_req` first reads high in the cycle after the d-th clock edge following the acceptance edge. With d = 0 it is high in the cycle right after acceptance.
- R5: `bus_req` stays high until `bus_gnt` is sampled high on a clock edge, and it is low in the cycle after that edge.
- R6: In the single cycle after the grant edge, `bus_addr_phase` is 1 and `bus_addr`, `bus_dir` and `bus_size` carry the command's values. Outside that cycle they read 0.
- R7: The data phase begins in the cycle after the address phase. The first data-phase clock edge ignores `bus_wait`. While `bus_data_phase` is 1 on a write, `bus_wdata` carries the write data, and it is 0 otherwise.
- R8: After the first data-phase edge, the engine leaves the data phase on the first edge where `bus_wait` is 0. On a read, `bus_rdata` is captured on that edge. `rsp_valid` rises in the next cycle with the command's identifier, the master index, the captured read data (0 for a write) and error 0.
- R9: If `bus_wait` is sampled high on WAIT_TIMEOUT+1 consecutive wait-checking edges, the engine abandons the transfer on the last of them. It then responds in the next cycle with error 1 and read data 0.
- R10: `rsp_valid` is high for exactly one cycle, and the engine is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine is idle and can take a command |
| cmd_id | input | 8 | Command identifier |
| cmd_addr | input | 16 | Transfer address |
| cmd_dir | input | 2 | Direction: 0 none, 1 read, 2 write, 3 none |
| cmd_wdata | input | 8 | Write data |
| cmd_size | input | 2 | Size code passed to the bus |
| cmd_delay | input | 4 | Idle cycles before arbitration |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_id | output | 8 | Identifier of the completed command |
| rsp_master | output | 2 | Master index of this engine |
| rsp_rdata | output | 8 | Captured read data |
| rsp_error | output | 1 | Wait timeout occurred |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter for this engine |
| bus_addr_phase | output | 1 | Address phase strobe |
| bus_addr | output | 16 | Address on the bus |
| bus_dir | output | 2 | Direction on the bus |
| bus_size | output | 2 | Size on the bus |
| bus_data_phase | output | 1 | Data phase indicator |
| bus_wdata | output | 8 | Write data on the bus |
| bus_rdata | input | 8 | Read data from the slave |
| bus_wait | input | 1 | Slave wait state request |

## Verification
Every result has a fixed cycle position measured from the accepting edge. A no-operation response is due one cycle later. The request line is due d cycles later. The address phase is due in the cycle after the sampled grant, and the data phase one cycle after that. The response is due in the cycle after the first low wait, or after the WAIT_TIMEOUT+1-th high wait. The bench drives its inputs on falling edges and reads the outputs on the next falling edge. It counts falling edges from acceptance and compares each count with the count worked out from the command's delay, grant latency and wait schedule. The wait input is held high during the ignored first data-phase edge, so that sampling it there would show up as a wrong count.

// File: rtl/busm_pkg.sv
package busm_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int SIZE_W = 2;
    parameter int ID_W   = 8;
    parameter int DLY_W  = 4;

    typedef enum logic [1:0] {
        DIR_NOP  = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2,
        DIR_RSVD = 2'd3
    } busm_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ARB,
        ST_ADDR,
        ST_DFIX,
        ST_DATA,
        ST_RESP
    } busm_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        busm_dir_e         dir;
        logic [DATA_W-1:0] wdata;
        logic [SIZE_W-1:0] size;
    } busm_cmd_t;

    function automatic logic dir_uses_bus(busm_dir_e d);
        return (d == DIR_RD) || (d == DIR_WR);
    endfunction

endpackage

// File: rtl/busm_cmd_buf.sv
module busm_cmd_buf
    import busm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  busm_cmd_t cmd_in,
    output busm_cmd_t cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= cmd_in;
        end
    end

endmodule

// File: rtl/busm_delay_timer.sv
module busm_delay_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/busm_wait_watch.sv
module busm_wait_watch #(
    parameter int WAIT_TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hit,
    output logic expired
);

    localparam int TO_W = $clog2(WAIT_TIMEOUT + 2);

    logic [TO_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wcnt <= '0;
        end else if (hit && !expired) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assign expired = (wcnt == TO_W'(WAIT_TIMEOUT));

    always_ff @(posedge clk) begin
        if (!rst) begin
            AST_WCNT_BOUND: assert (wcnt <= TO_W'(WAIT_TIMEOUT)); // R9
        end
    end

endmodule

// File: rtl/busm_ctrl_fsm.sv
module busm_ctrl_fsm
    import busm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  busm_dir_e         in_dir,
    input  logic              in_delay_zero,
    input  busm_dir_e         cur_dir,
    input  logic              dly_last,
    input  logic              wait_expired,
    input  logic              bus_gnt,
    input  logic              bus_wait,
    input  logic [DATA_W-1:0] bus_rdata,
    output busm_state_e       st,
    output logic [DATA_W-1:0] rdata_q,
    output logic              err_q
);

    busm_state_e nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (!dir_uses_bus(in_dir)) nxt = ST_RESP;
                    else if (!in_delay_zero)   nxt = ST_DELAY;
                    else                       nxt = ST_ARB;
                end
            end
            ST_DELAY: if (dly_last) nxt = ST_ARB;
            ST_ARB:   if (bus_gnt)  nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_DFIX;
            ST_DFIX:  nxt = ST_DATA;
            ST_DATA:  if (!bus_wait || wait_expired) nxt = ST_RESP;
            ST_RESP:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (st == ST_IDLE && accept) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (st == ST_DATA) begin
            if (!bus_wait) begin
                rdata_q <= (cur_dir == DIR_RD) ? bus_rdata : '0;
            end else if (wait_expired) begin
                err_q <= 1'b1;
            end
        end
    end

    AST_GNT_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARB && bus_gnt) |=> (st == ST_ADDR)); // R5
    AST_DFIX_IGNORES_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DFIX) |=> (st == ST_DATA)); // R7
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && bus_wait && !wait_expired) |=> (st == ST_DATA)); // R8

endmodule

// File: rtl/busm_xfer_engine.sv
module busm_xfer_engine
    import busm_pkg::*;
#(
    parameter int MASTER_IDX   = 0,
    parameter int MIDX_W       = 2,
    parameter int WAIT_TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_dir,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic [DLY_W-1:0]  cmd_delay,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [MIDX_W-1:0] rsp_master,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_addr_phase,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_dir,
    output logic [SIZE_W-1:0] bus_size,
    output logic              bus_data_phase,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wait
);

    busm_state_e st;
    busm_cmd_t   cmd_in;
    busm_cmd_t   cmd_q;
    logic        accept;
    logic        dly_last;
    logic        wait_expired;

    assign cmd_ready = (st == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        cmd_in       = '0;
        cmd_in.id    = cmd_id;
        cmd_in.addr  = cmd_addr;
        cmd_in.dir   = busm_dir_e'(cmd_dir);
        cmd_in.wdata = cmd_wdata;
        cmd_in.size  = cmd_size;
    end

    busm_cmd_buf u_cmd_buf (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cmd_in (cmd_in),
        .cmd_q  (cmd_q)
    );

    busm_delay_timer #(.CNT_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cmd_delay),
        .dec      (st == ST_DELAY),
        .last     (dly_last)
    );

    busm_wait_watch #(.WAIT_TIMEOUT(WAIT_TIMEOUT)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .clr     (st == ST_DFIX),
        .hit     ((st == ST_DATA) && bus_wait),
        .expired (wait_expired)
    );

    busm_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .in_dir        (busm_dir_e'(cmd_dir)),
        .in_delay_zero (cmd_delay == '0),
        .cur_dir       (cmd_q.dir),
        .dly_last      (dly_last),
        .wait_expired  (wait_expired),
        .bus_gnt       (bus_gnt),
        .bus_wait      (bus_wait),
        .bus_rdata     (bus_rdata),
        .st            (st),
        .rdata_q       (rsp_rdata),
        .err_q         (rsp_error)
    );

    assign bus_req        = (st == ST_ARB);
    assign bus_addr_phase = (st == ST_ADDR);
    assign bus_data_phase = (st == ST_DFIX) || (st == ST_DATA);
    assign bus_addr       = bus_addr_phase ? cmd_q.addr : '0;
    assign bus_dir        = bus_addr_phase ? cmd_q.dir  : DIR_NOP;
    assign bus_size       = bus_addr_phase ? cmd_q.size : '0;
    assign bus_wdata      = (bus_data_phase && cmd_q.dir == DIR_WR) ? cmd_q.wdata : '0;

    assign rsp_valid  = (st == ST_RESP);
    assign rsp_id     = cmd_q.id;
    assign rsp_master = MIDX_W'(MASTER_IDX);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && cmd_ready)); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cmd_ready); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req); // R5
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> (!bus_req && bus_addr_phase)); // R6
    AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_addr_phase |=> (!bus_addr_phase && bus_data_phase)); // R6
    AST_NOP_SKIPS_BUS: assert property (@(posedge clk) disable iff (rst)
        (accept && !dir_uses_bus(busm_dir_e'(cmd_dir))) |=> (rsp_valid && !rsp_error)); // R3
    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && !bus_wait && cmd_q.dir == DIR_RD)
        |=> (rsp_valid && !rsp_error && rsp_rdata == $past(bus_rdata))); // R8
    AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && bus_wait && wait_expired) |=> (rsp_valid && rsp_error)); // R9

endmodule

// File: tb/tb_busm_xfer_engine.sv
module tb_busm_xfer_engine;

    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [7:0]  cmd_id;
    logic [15:0] cmd_addr;
    logic [1:0]  cmd_dir;
    logic [7:0]  cmd_wdata;
    logic [1:0]  cmd_size;
    logic [3:0]  cmd_delay;
    logic        rsp_valid;
    logic [7:0]  rsp_id;
    logic [1:0]  rsp_master;
    logic [7:0]  rsp_rdata;
    logic        rsp_error;
    logic        bus_req;
    logic        bus_gnt;
    logic        bus_addr_phase;
    logic [15:0] bus_addr;
    logic [1:0]  bus_dir;
    logic [1:0]  bus_size;
    logic        bus_data_phase;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_wait;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    busm_xfer_engine #(.MASTER_IDX(2), .MIDX_W(2), .WAIT_TIMEOUT(TO)) dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
        .cmd_addr(cmd_addr), .cmd_dir(cmd_dir), .cmd_wdata(cmd_wdata),
        .cmd_size(cmd_size), .cmd_delay(cmd_delay),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_master(rsp_master),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr_phase(bus_addr_phase),
        .bus_addr(bus_addr), .bus_dir(bus_dir), .bus_size(bus_size),
        .bus_data_phase(bus_data_phase), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit uses_bus(input logic [1:0] d);
        return (d == 2'd1) || (d == 2'd2);
    endfunction

    function automatic int exp_wait_edges(input int waits);
        return (waits > TO) ? TO : waits;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] d, input int waits,
                                             input logic [7:0] last_rd);
        return (d == 2'd1 && waits <= TO) ? last_rd : 8'h00;
    endfunction

    // One complete transfer; inputs change on falling edges, outputs read there too.
    task automatic xfer(input logic [7:0] id, input logic [15:0] addr,
                        input logic [1:0] dir, input logic [7:0] wd,
                        input logic [1:0] sz, input int dly,
                        input int gnt_lat, input int waits);
        int cnt;
        logic [7:0] last_rd;
        chk("R2", "ready before command", 32'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_id = id; cmd_addr = addr; cmd_dir = dir;
        cmd_wdata = wd; cmd_size = sz; cmd_delay = 4'(dly);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2", "ready while busy", 32'(cmd_ready), 0);
        if (!uses_bus(dir)) begin
            chk("R3", "no-op response", 32'(rsp_valid), 1);
            chk("R3", "no-op bus_req", 32'(bus_req), 0);
            chk("R3", "no-op error", 32'(rsp_error), 0);
            chk("R3", "no-op rdata", 32'(rsp_rdata), 0);
            chk("R3", "no-op id", 32'(rsp_id), 32'(id));
        end else begin
            cnt = 0;
            while (!bus_req && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            chk("R4", "delay cycles before request", cnt, dly);
            for (int j = 0; j < gnt_lat; j++) begin
                @(negedge clk);
                chk("R5", "request held without grant", 32'(bus_req), 1);
            end
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            chk("R5", "request dropped after grant", 32'(bus_req), 0);
            chk("R6", "address phase strobe", 32'(bus_addr_phase), 1);
            chk("R6", "address", 32'(bus_addr), 32'(addr));
            chk("R6", "direction", 32'(bus_dir), 32'(dir));
            chk("R6", "size", 32'(bus_size), 32'(sz));
            bus_wait = 1'b1;
            @(negedge clk);
            chk("R6", "address phase ends", 32'(bus_addr_phase), 0);
            chk("R7", "data phase begins", 32'(bus_data_phase), 1);
            chk("R7", "write data", 32'(bus_wdata), (dir == 2'd2) ? 32'(wd) : 0);
            // bus_wait stays high across the ignored first data-phase edge
            @(negedge clk);
            cnt = 0;
            last_rd = 8'h00;
            while (!rsp_valid && cnt < 40) begin
                chk("R7", "still in data phase", 32'(bus_data_phase), 1);
                bus_wait  = (cnt < waits);
                last_rd   = 8'($urandom);
                bus_rdata = last_rd;
                @(negedge clk);
                if (!rsp_valid) cnt++;
            end
            bus_wait = 1'b0;
            if (waits > TO) begin
                chk("R9", "wait edges before abort", cnt, exp_wait_edges(waits));
                chk("R9", "timeout error", 32'(rsp_error), 1);
                chk("R9", "timeout rdata", 32'(rsp_rdata), 0);
            end else begin
                chk("R8", "wait edges before finish", cnt, exp_wait_edges(waits));
                chk("R8", "error clear", 32'(rsp_error), 0);
                chk("R8", "read data", 32'(rsp_rdata), 32'(exp_rdata(dir, waits, last_rd)));
            end
            chk("R8", "response id", 32'(rsp_id), 32'(id));
            chk("R8", "master index", 32'(rsp_master), 2);
        end
        @(negedge clk);
        chk("R10", "response one cycle", 32'(rsp_valid), 0);
        chk("R10", "idle after response", 32'(cmd_ready), 1);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_id = '0; cmd_addr = '0; cmd_dir = '0;
        cmd_wdata = '0; cmd_size = '0; cmd_delay = '0; bus_gnt = 1'b0;
        bus_rdata = '0; bus_wait = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset ready", 32'(cmd_ready), 1);
        chk("R1", "reset bus_req", 32'(bus_req), 0);
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "reset address phase", 32'(bus_addr_phase), 0);
        chk("R1", "reset data phase", 32'(bus_data_phase), 0);

        xfer(8'h01, 16'h1234, 2'd0, 8'hAA, 2'd1, 5, 0, 0);   // R3 no-op
        xfer(8'h02, 16'hFFFF, 2'd3, 8'h55, 2'd2, 0, 0, 0);   // R3 reserved code
        xfer(8'h03, 16'h4000, 2'd2, 8'h5A, 2'd0, 0, 0, 0);   // write, no waits
        xfer(8'h04, 16'h8001, 2'd1, 8'h00, 2'd1, 3, 2, 1);   // read, delay 3
        xfer(8'h05, 16'hC0DE, 2'd1, 8'h00, 2'd3, 15, 1, TO); // R9 boundary, completes
        xfer(8'h06, 16'h0F0F, 2'd1, 8'h00, 2'd0, 1, 0, TO + 1); // R9 abort
        xfer(8'h07, 16'h7FFE, 2'd2, 8'h3C, 2'd1, 0, 4, TO + 3); // R9 abort write

        for (int i = 0; i < 40; i++) begin
            logic [1:0] d;
            d = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) d = 2'($urandom_range(1, 2));
            xfer(8'(i + 16), 16'($urandom), d, 8'($urandom), 2'($urandom),
                 $urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, TO + 2));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule